// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vector Controller

This block holds the interrupt bookkeeping for a two-channel serial controller. Each channel (channel A at index 0, channel B at index 1) keeps a receive-pending flag, a transmit-pending flag, and one under-service flag for each direction. Strobes from the surrounding data path update these flags: a byte arrived, the data port was read, the data port was written, a break was seen, a clear-transmit-interrupt command, and an end-of-service command. Receive outranks transmit. A receive under service stops a new transmit interrupt from being posted until the receive is served or its service ends.

From these flags the block keeps a shared 8-bit pending-source register and an 8-bit interrupt vector. The vector names the most recent source that was posted, or "none", and a select input moves the code to a different bit position. One active-high interrupt output is the OR of the requests from both channels. Each request is gated by the enable bits that the write registers supply.

Top module: `sio_irq_vector_ctrl`

## Requirements
- R1: After synchronous reset, irq is 0, pend_flags is 8'h00, int_vector is 8'h00, and rx_avail and brk_seen are 2'b00.
- R2: A rx_strobe for channel c is accepted only when rx_enable[c] is 1 and rx_avail[c] is 0. An accepted byte sets rx_avail[c] on the next clock edge. A rejected strobe leaves every output unchanged.
- R3: An accepted byte always marks receive pending and receive under service. It sets the receive bit in pend_flags (bit 5 for A, bit 2 for B) and loads the receive code into int_vector, whatever the transmit state.
- R4: A data write marks transmit pending. When no receive is under service on that channel, it also marks transmit under service and loads the transmit code into int_vector. If tx_irq_en[c] is 1 at that moment, it sets the transmit bit in pend_flags (bit 4 for A, bit 1 for B). Otherwise pend_flags and int_vector are left unchanged.
- R5: int_vector codes, with vec_hi_sel=0: A receive 8'h0C, A transmit 8'h08, B receive 8'h04, B transmit 8'h00, none 8'h06. With vec_hi_sel=1: 8'h30, 8'h10, 8'h20, 8'h00 and 8'h60.
- R6: A data read clears rx_avail[c], receive pending, receive under service and the receive bit of pend_flags, and sets int_vector to the none code. A transmit still pending on that channel is then posted again as in R4.
- R7: clr_tx_strobe clears transmit pending, transmit under service and the transmit bit of pend_flags, and sets int_vector to the none code. A receive still pending on that channel is then posted again as in R3.
- R8: rst_ius_strobe ends a receive service if one is active and then posts again a transmit that is still pending. When no receive is under service, it ends the transmit service only, and the outputs do not change.
- R9: irq is 1 when, on either channel, (tx_irq_en[c] and transmit pending) or (rx_irq_mode field of c equal to 2'b01 or 2'b10 and receive pending) or (brk_irq_en[c] and brk_seen[c]). Mode field c is rx_irq_mode[2c+1:2c]. Modes 2'b00 and 2'b11 raise no receive request.
- R10: brk_strobe[c] sets brk_seen[c]. The flag stays set until reset.
- R11: Strobes in the same cycle are applied in this order: receive, then write, then read, then clear-transmit, then end-of-service. All of channel A is applied before channel B, so the vector shows the last source applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_strobe | input | 2 | Byte-arrived strobe per channel |
| wr_strobe | input | 2 | Data-port write strobe per channel |
| rd_strobe | input | 2 | Data-port read strobe per channel |
| clr_tx_strobe | input | 2 | Clear-transmit-interrupt command per channel |
| rst_ius_strobe | input | 2 | End-of-service command per channel |
| brk_strobe | input | 2 | Break detected per channel |
| rx_enable | input | 2 | Receiver enable per channel |
| tx_irq_en | input | 2 | Transmit interrupt enable per channel |
| rx_irq_mode | input | 4 | Receive interrupt mode, 2 bits per channel |
| brk_irq_en | input | 2 | Break interrupt enable per channel |
| vec_hi_sel | input | 1 | Selects the high vector position |
| irq | output | 1 | Combined interrupt request |
| pend_flags | output | 8 | Shared pending-source register |
| int_vector | output | 8 | Encoded interrupt vector |
| rx_avail | output | 2 | Received byte available per channel |
| brk_seen | output | 2 | Sticky break flag per channel |

## Verification
The assertions assume that every strobe is synchronous to clk and lasts one cycle, and that enables and vec_hi_sel change only between edges. They also assume the block leaves reset only after at least one edge with rst high. The bench drives every input on the falling edge and holds strobes for exactly one cycle. It reapplies reset before each scenario, so each expected value starts from the known R1 state. It changes enables only while no strobe is active, so the request gating it checks reflects state that is already settled.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

    localparam int NCH    = 2;
    localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int VEC_W  = 8;
    localparam int BIT_W  = $clog2(VEC_W);
    localparam int CODE_W = 3;
    localparam int MODE_W = 2;

    typedef logic [CH_W-1:0]  ch_idx_t;
    typedef logic [BIT_W-1:0] pbit_t;

    // source codes; the low vector position uses them directly,
    // the high position uses them bit-reversed
    typedef enum logic [CODE_W-1:0] {
        SRC_TX_B = 3'b000,
        SRC_RX_B = 3'b010,
        SRC_NONE = 3'b011,
        SRC_TX_A = 3'b100,
        SRC_RX_A = 3'b110
    } src_code_e;

    typedef struct packed {
        logic rx_pend;
        logic tx_pend;
        logic rx_svc;
        logic tx_svc;
        logic rx_avail;
        logic brk;
    } chan_state_t;

    typedef struct packed {
        chan_state_t [NCH-1:0] ch;
        logic [VEC_W-1:0]      pend;
        logic [VEC_W-1:0]      vec;
    } ctl_state_t;

    typedef struct packed {
        logic rx_ok;
        logic wr;
        logic rd;
        logic clr_tx;
        logic rst_ius;
        logic brk;
    } chan_evt_t;

    function automatic logic [VEC_W-1:0] encode_vec(src_code_e src, logic hi);
        logic [CODE_W-1:0] k;
        k = src;
        if (hi)
            return {1'b0, k[0], k[1], k[2], 4'b0000};
        return {4'b0000, k, 1'b0};
    endfunction

    function automatic pbit_t rx_bit(ch_idx_t c);
        return (c == ch_idx_t'(0)) ? pbit_t'(5) : pbit_t'(2);
    endfunction

    function automatic pbit_t tx_bit(ch_idx_t c);
        return (c == ch_idx_t'(0)) ? pbit_t'(4) : pbit_t'(1);
    endfunction

    function automatic src_code_e rx_src(ch_idx_t c);
        return (c == ch_idx_t'(0)) ? SRC_RX_A : SRC_RX_B;
    endfunction

    function automatic src_code_e tx_src(ch_idx_t c);
        return (c == ch_idx_t'(0)) ? SRC_TX_A : SRC_TX_B;
    endfunction

    function automatic logic rx_mode_on(logic [MODE_W-1:0] m);
        return (m == 2'b01) || (m == 2'b10);
    endfunction

    function automatic ctl_state_t post_rx(ctl_state_t s, ch_idx_t c, logic hi);
        ctl_state_t n;
        n = s;
        n.ch[c].rx_pend  = 1'b1;
        n.ch[c].rx_svc   = 1'b1;
        n.pend[rx_bit(c)] = 1'b1;
        n.vec = encode_vec(rx_src(c), hi);
        return n;
    endfunction

    function automatic ctl_state_t post_tx(ctl_state_t s, ch_idx_t c, logic hi,
                                           logic en);
        ctl_state_t n;
        n = s;
        n.ch[c].tx_pend = 1'b1;
        if (!n.ch[c].rx_svc) begin
            n.ch[c].tx_svc = 1'b1;
            if (en)
                n.pend[tx_bit(c)] = 1'b1;
            n.vec = encode_vec(tx_src(c), hi);
        end
        return n;
    endfunction

    function automatic ctl_state_t drop_rx(ctl_state_t s, ch_idx_t c, logic hi,
                                           logic en);
        ctl_state_t n;
        n = s;
        n.ch[c].rx_pend   = 1'b0;
        n.ch[c].rx_svc    = 1'b0;
        n.pend[rx_bit(c)] = 1'b0;
        n.vec = encode_vec(SRC_NONE, hi);
        if (n.ch[c].tx_pend)
            n = post_tx(n, c, hi, en);
        return n;
    endfunction

    function automatic ctl_state_t drop_tx(ctl_state_t s, ch_idx_t c, logic hi);
        ctl_state_t n;
        n = s;
        n.ch[c].tx_pend   = 1'b0;
        n.ch[c].tx_svc    = 1'b0;
        n.pend[tx_bit(c)] = 1'b0;
        n.vec = encode_vec(SRC_NONE, hi);
        if (n.ch[c].rx_pend)
            n = post_rx(n, c, hi);
        return n;
    endfunction

    function automatic ctl_state_t end_service(ctl_state_t s, ch_idx_t c, logic hi,
                                               logic en);
        ctl_state_t n;
        n = s;
        if (n.ch[c].rx_svc) begin
            n.ch[c].rx_svc = 1'b0;
            if (n.ch[c].tx_pend)
                n = post_tx(n, c, hi, en);
        end else begin
            n.ch[c].tx_svc = 1'b0;
        end
        return n;
    endfunction

    // fixed order: break, receive, write, read, clear-transmit, end-of-service
    function automatic ctl_state_t step_channel(ctl_state_t s, ch_idx_t c,
                                                chan_evt_t e, logic hi, logic en);
        ctl_state_t n;
        n = s;
        if (e.brk)
            n.ch[c].brk = 1'b1;
        if (e.rx_ok) begin
            n.ch[c].rx_avail = 1'b1;
            n = post_rx(n, c, hi);
        end
        if (e.wr) begin
            n.ch[c].tx_pend = 1'b0;
            n = post_tx(n, c, hi, en);
        end
        if (e.rd) begin
            n.ch[c].rx_avail = 1'b0;
            n = drop_rx(n, c, hi, en);
        end
        if (e.clr_tx)
            n = drop_tx(n, c, hi);
        if (e.rst_ius)
            n = end_service(n, c, hi, en);
        return n;
    endfunction

endpackage

// File: rtl/sio_irq_chan_front.sv
module sio_irq_chan_front
    import sio_irq_pkg::*;
(
    input  logic      rx_strobe,
    input  logic      rx_enable,
    input  logic      rx_avail,
    input  logic      wr_strobe,
    input  logic      rd_strobe,
    input  logic      clr_tx_strobe,
    input  logic      rst_ius_strobe,
    input  logic      brk_strobe,
    output chan_evt_t evt
);

    always_comb begin
        evt         = '0;
        evt.rx_ok   = rx_strobe && rx_enable && !rx_avail;
        evt.wr      = wr_strobe;
        evt.rd      = rd_strobe;
        evt.clr_tx  = clr_tx_strobe;
        evt.rst_ius = rst_ius_strobe;
        evt.brk     = brk_strobe;
    end

endmodule

// File: rtl/sio_irq_engine.sv
module sio_irq_engine
    import sio_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  chan_evt_t [NCH-1:0]   evt,
    input  logic      [NCH-1:0]   tx_en,
    input  logic                  vec_hi,
    output ctl_state_t            state
);

    ctl_state_t cur_q;
    ctl_state_t nxt;

    always_comb begin
        nxt = cur_q;
        for (int c = 0; c < NCH; c++) begin
            nxt = step_channel(nxt, ch_idx_t'(c), evt[c], vec_hi, tx_en[c]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur_q <= '0;
        else
            cur_q <= nxt;
    end

    assign state = cur_q;

endmodule

// File: rtl/sio_irq_chan_req.sv
module sio_irq_chan_req
    import sio_irq_pkg::*;
(
    input  chan_state_t         st,
    input  logic                tx_en,
    input  logic [MODE_W-1:0]   rx_mode,
    input  logic                brk_en,
    output logic                req
);

    logic tx_req;
    logic rx_req;
    logic brk_req;

    assign tx_req  = tx_en && st.tx_pend;
    assign rx_req  = rx_mode_on(rx_mode) && st.rx_pend;
    assign brk_req = brk_en && st.brk;
    assign req     = tx_req || rx_req || brk_req;

endmodule

// File: rtl/sio_irq_vector_ctrl.sv
module sio_irq_vector_ctrl
    import sio_irq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NCH-1:0]          rx_strobe,
    input  logic [NCH-1:0]          wr_strobe,
    input  logic [NCH-1:0]          rd_strobe,
    input  logic [NCH-1:0]          clr_tx_strobe,
    input  logic [NCH-1:0]          rst_ius_strobe,
    input  logic [NCH-1:0]          brk_strobe,
    input  logic [NCH-1:0]          rx_enable,
    input  logic [NCH-1:0]          tx_irq_en,
    input  logic [MODE_W*NCH-1:0]   rx_irq_mode,
    input  logic [NCH-1:0]          brk_irq_en,
    input  logic                    vec_hi_sel,
    output logic                    irq,
    output logic [VEC_W-1:0]        pend_flags,
    output logic [VEC_W-1:0]        int_vector,
    output logic [NCH-1:0]          rx_avail,
    output logic [NCH-1:0]          brk_seen
);

    chan_evt_t [NCH-1:0] evt;
    ctl_state_t          state;
    logic      [NCH-1:0] req;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        sio_irq_chan_front u_front (
            .rx_strobe      (rx_strobe[c]),
            .rx_enable      (rx_enable[c]),
            .rx_avail       (state.ch[c].rx_avail),
            .wr_strobe      (wr_strobe[c]),
            .rd_strobe      (rd_strobe[c]),
            .clr_tx_strobe  (clr_tx_strobe[c]),
            .rst_ius_strobe (rst_ius_strobe[c]),
            .brk_strobe     (brk_strobe[c]),
            .evt            (evt[c])
        );

        sio_irq_chan_req u_req (
            .st      (state.ch[c]),
            .tx_en   (tx_irq_en[c]),
            .rx_mode (rx_irq_mode[MODE_W*c +: MODE_W]),
            .brk_en  (brk_irq_en[c]),
            .req     (req[c])
        );

        assign rx_avail[c] = state.ch[c].rx_avail;
        assign brk_seen[c] = state.ch[c].brk;
    end

    sio_irq_engine u_engine (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .tx_en  (tx_irq_en),
        .vec_hi (vec_hi_sel),
        .state  (state)
    );

    assign irq        = |req;
    assign pend_flags = state.pend;
    assign int_vector = state.vec;

endmodule

// File: rtl/sio_irq_vector_ctrl_chk.sv
module sio_irq_vector_ctrl_chk
    import sio_irq_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic [NCH-1:0]          rx_strobe,
    input logic [NCH-1:0]          wr_strobe,
    input logic [NCH-1:0]          rd_strobe,
    input logic [NCH-1:0]          clr_tx_strobe,
    input logic [NCH-1:0]          rst_ius_strobe,
    input logic [NCH-1:0]          brk_strobe,
    input logic [NCH-1:0]          rx_enable,
    input logic [NCH-1:0]          tx_irq_en,
    input logic [MODE_W*NCH-1:0]   rx_irq_mode,
    input logic [NCH-1:0]          brk_irq_en,
    input logic                    vec_hi_sel,
    input logic                    irq,
    input logic [VEC_W-1:0]        pend_flags,
    input logic [VEC_W-1:0]        int_vector,
    input logic [NCH-1:0]          rx_avail,
    input logic [NCH-1:0]          brk_seen
);

    logic no_rx_mode;
    assign no_rx_mode = !rx_mode_on(rx_irq_mode[1:0]) && !rx_mode_on(rx_irq_mode[3:2]);

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        p_rx_accept_r2: assert property (@(posedge clk) disable iff (rst)
            (rx_strobe[c] && rx_enable[c] && !rx_avail[c] && !rd_strobe[c]) |=> rx_avail[c]);

        p_rx_idle_r2: assert property (@(posedge clk) disable iff (rst)
            (!rx_avail[c] && !(rx_strobe[c] && rx_enable[c])) |=> !rx_avail[c]);

        p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
            rd_strobe[c] |=> !rx_avail[c]);

        p_brk_sticky_r10: assert property (@(posedge clk) disable iff (rst)
            brk_seen[c] |=> brk_seen[c]);

        p_brk_irq_r9: assert property (@(posedge clk) disable iff (rst)
            (brk_irq_en[c] && brk_seen[c]) |-> irq);
    end

    p_vec_legal_r5: assert property (@(posedge clk) disable iff (rst)
        int_vector inside {8'h00, 8'h04, 8'h06, 8'h08, 8'h0C,
                           8'h10, 8'h20, 8'h30, 8'h60});

    p_pend_unused_r3: assert property (@(posedge clk) disable iff (rst)
        (pend_flags & 8'hC9) == 8'h00);

    p_rx_a_irq_r9: assert property (@(posedge clk) disable iff (rst)
        (pend_flags[5] && rx_mode_on(rx_irq_mode[1:0])) |-> irq);

    p_rx_b_irq_r9: assert property (@(posedge clk) disable iff (rst)
        (pend_flags[2] && rx_mode_on(rx_irq_mode[3:2])) |-> irq);

    p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_irq_en == '0 && brk_irq_en == '0 && no_rx_mode) |-> !irq);

endmodule

bind sio_irq_vector_ctrl sio_irq_vector_ctrl_chk u_chk (.*);

// File: tb/tb_sio_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_sio_irq_vector_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] rx_strobe, wr_strobe, rd_strobe, clr_tx_strobe, rst_ius_strobe, brk_strobe;
    logic [1:0] rx_enable, tx_irq_en, brk_irq_en;
    logic [3:0] rx_irq_mode;
    logic       vec_hi_sel;
    logic       irq;
    logic [7:0] pend_flags, int_vector;
    logic [1:0] rx_avail, brk_seen;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    sio_irq_vector_ctrl dut (
        .clk(clk), .rst(rst),
        .rx_strobe(rx_strobe), .wr_strobe(wr_strobe), .rd_strobe(rd_strobe),
        .clr_tx_strobe(clr_tx_strobe), .rst_ius_strobe(rst_ius_strobe),
        .brk_strobe(brk_strobe), .rx_enable(rx_enable), .tx_irq_en(tx_irq_en),
        .rx_irq_mode(rx_irq_mode), .brk_irq_en(brk_irq_en), .vec_hi_sel(vec_hi_sel),
        .irq(irq), .pend_flags(pend_flags), .int_vector(int_vector),
        .rx_avail(rx_avail), .brk_seen(brk_seen)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        {rx_strobe, wr_strobe, rd_strobe, clr_tx_strobe, rst_ius_strobe, brk_strobe} = '0;
        rx_enable = 2'b11; tx_irq_en = 2'b11; brk_irq_en = 2'b00;
        rx_irq_mode = 4'b0000; vec_hi_sel = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // one-cycle strobes; on return the edge has been taken and outputs are settled
    task automatic fire(input logic [1:0] rx, input logic [1:0] wr, input logic [1:0] rd,
                        input logic [1:0] clt, input logic [1:0] rius, input logic [1:0] brk);
        @(negedge clk);
        rx_strobe = rx; wr_strobe = wr; rd_strobe = rd;
        clr_tx_strobe = clt; rst_ius_strobe = rius; brk_strobe = brk;
        @(negedge clk);
        {rx_strobe, wr_strobe, rd_strobe, clr_tx_strobe, rst_ius_strobe, brk_strobe} = '0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        do_reset();
        check("R1 irq", {7'b0, irq}, 8'h00);
        check("R1 pend", pend_flags, 8'h00);
        check("R1 vector", int_vector, 8'h00);
        check("R1 rx_avail", {6'b0, rx_avail}, 8'h00);
        check("R1 brk_seen", {6'b0, brk_seen}, 8'h00);
    endtask

    task automatic t_rx_gate();
        do_reset();
        rx_enable = 2'b00; tx_irq_en = 2'b10;
        fire(2'b01, 0, 0, 0, 0, 0);
        check("R2 disabled rx_avail", {6'b0, rx_avail}, 8'h00);
        check("R2 disabled pend", pend_flags, 8'h00);
        rx_enable = 2'b11;
        fire(2'b01, 0, 0, 0, 0, 0);
        check("R2 accepted rx_avail", {6'b0, rx_avail}, 8'h01);
        check("R3 A rx pend", pend_flags, 8'h20);
        check("R3 A rx vector", int_vector, 8'h0C);
        fire(0, 2'b10, 0, 0, 0, 0);
        check("R4 B tx pend", pend_flags, 8'h22);
        check("R5 B tx vector lo", int_vector, 8'h00);
        fire(2'b01, 0, 0, 0, 0, 0);
        check("R2 rejected while avail vector", int_vector, 8'h00);
        check("R2 rejected while avail pend", pend_flags, 8'h22);
    endtask

    task automatic t_irq_modes();
        do_reset();
        tx_irq_en = 2'b00;
        fire(2'b10, 0, 0, 0, 0, 0);
        check("R3 B rx vector", int_vector, 8'h04);
        check("R9 mode00 no irq", {7'b0, irq}, 8'h00);
        rx_irq_mode = 4'b0100; @(negedge clk);
        check("R9 mode01 irq", {7'b0, irq}, 8'h01);
        rx_irq_mode = 4'b1000; @(negedge clk);
        check("R9 mode10 irq", {7'b0, irq}, 8'h01);
        rx_irq_mode = 4'b1100; @(negedge clk);
        check("R9 mode11 no irq", {7'b0, irq}, 8'h00);
        rx_irq_mode = 4'b0000;
        fire(0, 2'b01, 0, 0, 0, 0);
        check("R4 tx disabled pend", pend_flags, 8'h04);
        check("R4 tx disabled vector", int_vector, 8'h08);
        check("R9 tx disabled no irq", {7'b0, irq}, 8'h00);
        tx_irq_en = 2'b01; @(negedge clk);
        check("R9 tx enabled irq", {7'b0, irq}, 8'h01);
        check("R4 pend unchanged after enable", pend_flags, 8'h04);
    endtask

    task automatic t_ius();
        do_reset();
        rx_irq_mode = 4'b0001;
        fire(2'b01, 0, 0, 0, 0, 0);
        fire(0, 2'b01, 0, 0, 0, 0);
        check("R4 tx blocked pend", pend_flags, 8'h20);
        check("R4 tx blocked vector", int_vector, 8'h0C);
        fire(0, 0, 0, 0, 2'b01, 0);
        check("R8 end rx service pend", pend_flags, 8'h30);
        check("R8 end rx service vector", int_vector, 8'h08);
        fire(0, 0, 0, 0, 2'b01, 0);
        check("R8 end tx service pend", pend_flags, 8'h30);
        check("R8 end tx service vector", int_vector, 8'h08);
    endtask

    task automatic t_clears();
        do_reset();
        rx_irq_mode = 4'b0101;
        fire(2'b01, 0, 0, 0, 0, 0);
        fire(0, 2'b01, 0, 0, 0, 0);
        fire(0, 0, 2'b01, 0, 0, 0);
        check("R6 read rx_avail", {6'b0, rx_avail}, 8'h00);
        check("R6 read reposts tx pend", pend_flags, 8'h10);
        check("R6 read reposts tx vector", int_vector, 8'h08);
        fire(0, 0, 0, 2'b01, 0, 0);
        check("R7 clear tx pend", pend_flags, 8'h00);
        check("R7 clear tx vector none", int_vector, 8'h06);
        check("R7 clear tx irq", {7'b0, irq}, 8'h00);
        fire(2'b10, 0, 0, 0, 0, 0);
        fire(0, 2'b10, 0, 0, 0, 0);
        fire(0, 0, 0, 2'b10, 0, 0);
        check("R7 clear tx reposts rx vector", int_vector, 8'h04);
        check("R7 clear tx reposts rx pend", pend_flags, 8'h04);
    endtask

    task automatic t_vec_hi();
        do_reset();
        vec_hi_sel = 1'b1;
        fire(2'b01, 0, 0, 0, 0, 0);
        check("R5 hi A rx", int_vector, 8'h30);
        fire(2'b10, 0, 0, 0, 0, 0);
        check("R5 hi B rx", int_vector, 8'h20);
        check("R3 both rx pend", pend_flags, 8'h24);
        fire(0, 0, 2'b10, 0, 0, 0);
        check("R5 hi none", int_vector, 8'h60);
        fire(0, 2'b01, 0, 0, 0, 0);
        check("R4 hi blocked vector", int_vector, 8'h60);
        fire(0, 0, 2'b01, 0, 0, 0);
        check("R5 hi A tx", int_vector, 8'h10);
        check("R6 hi pend", pend_flags, 8'h10);
        fire(0, 2'b10, 0, 0, 0, 0);
        check("R5 hi B tx", int_vector, 8'h00);
        check("R4 hi pend", pend_flags, 8'h12);
    endtask

    task automatic t_break();
        do_reset();
        fire(0, 0, 0, 0, 0, 2'b01);
        check("R10 brk set", {6'b0, brk_seen}, 8'h01);
        check("R9 brk disabled irq", {7'b0, irq}, 8'h00);
        brk_irq_en = 2'b01; @(negedge clk);
        check("R9 brk enabled irq", {7'b0, irq}, 8'h01);
        fire(0, 0, 2'b01, 0, 2'b01, 0);
        repeat (3) @(negedge clk);
        check("R10 brk sticky", {6'b0, brk_seen}, 8'h01);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 brk cleared by reset", {6'b0, brk_seen}, 8'h00);
        check("R1 irq low after reset", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_order();
        do_reset();
        fire(2'b01, 2'b01, 0, 0, 0, 0);
        check("R11 rx before tx pend", pend_flags, 8'h20);
        check("R11 rx before tx vector", int_vector, 8'h0C);
        check("R11 rx before tx avail", {6'b0, rx_avail}, 8'h01);
        fire(0, 2'b01, 2'b01, 0, 0, 0);
        check("R11 write before read pend", pend_flags, 8'h10);
        check("R11 write before read vector", int_vector, 8'h08);
        check("R11 write before read avail", {6'b0, rx_avail}, 8'h00);
        fire(2'b11, 0, 0, 0, 0, 0);
        check("R11 A before B vector", int_vector, 8'h04);
        check("R11 A before B pend", pend_flags, 8'h34);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_rx_gate();
        t_irq_modes();
        t_ius();
        t_clears();
        t_vec_hi();
        t_break();
        t_order();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule